// File: doc/BRIEF.md
# Word Register File with Write and Read-Confirm Strobes

This block is a memory-mapped slave that holds a set of 32-bit registers, with at most 64 of them. The bus presents byte addresses. The block drops the two lowest address bits and uses the rest as the register word index. Each register has its own reset value and a 4-bit mode code. Bit 0 of that code decides whether the bus can write the register. If the bit is clear, the bus cannot write it, and a read returns a word supplied from outside the block.

Software often needs to trigger an action, and a plain register value cannot show that a write happened when the same value is written twice. Each register therefore drives a one-cycle write strobe on every write, and a read-confirm strobe when a read of it has been served. The register outputs and write strobes can be moved into a separate consumer clock domain. Each write crosses over through a toggle that is synchronised on the far side, so every bus write gives exactly one strobe pulse there. Transfers are always accepted at once.

Top module: `word_regfile_slave`

## Requirements
- R1: The waitrequest output stays low at all times, including during writes and reads.
- R2: The word index is the byte address shifted right by two. The two low address bits have no effect, so a write to byte address 4*i+3 lands in register i.
- R3: After reset, every register output word i equals its reset value, the read-back of a writable register equals that value, and read data valid and all strobes are low.
- R4: A write to a register whose mode bit 0 is 1 stores the write data. One bus cycle after a read request, read-data-valid is high with the addressed word on read data, and it is low in the cycle after a cycle with no read request.
- R5: A register whose mode bit 0 is 0 ignores writes. Its output keeps its reset value, its write strobe does not pulse, and a read returns external input word i (bits 32*i+31 to 32*i).
- R6: An access whose word index is NUM_REGS or larger changes no register and pulses no strobe. A read there returns zero with read-data-valid.
- R7: Each accepted write to a writable register produces exactly one write-strobe pulse for that register, lasting one cycle of the output clock, even when the value is unchanged.
- R8: A served read of register i raises read-confirm bit i for one bus cycle, in the same cycle as read-data-valid. A read beyond the register count raises no bit.
- R9: In the alternate-clock variant, the register output word already holds the new value in the output-clock cycle where its write strobe is high.
- R10: When write and read of the same register arrive in the same cycle, the read returns the value held before the write, and the register stores the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| busRst | input | 1 | Bus-domain reset, active high |
| busAddr | input | ADDR_W | Byte address |
| busWrite | input | 1 | Write request |
| busWriteData | input | 32 | Write data |
| busRead | input | 1 | Read request |
| busReadValid | output | 1 | Read data valid, one cycle after the read |
| busReadData | output | 32 | Read data |
| busWaitReq | output | 1 | Wait request, always low |
| altClk | input | 1 | Output-domain clock (unused when USE_ALT_CLK is 0) |
| altRst | input | 1 | Output-domain reset, active high |
| extIn | input | NUM_REGS*32 | External words returned by read-only registers |
| regOut | output | NUM_REGS*32 | Register contents, word i at bits 32*i+31 to 32*i |
| wrStrobe | output | NUM_REGS | Per-register write pulse |
| rdStrobe | output | NUM_REGS | Per-register read-confirm pulse (bus domain) |

## Verification
A write and a read can be accepted in the same bus cycle. If both name the same register, the read-back path and the storage update happen at the same edge. The bench raises write and read together on one register. It expects the old value in the read data of the following cycle and the new value on a later read, and it expects exactly one write strobe in the output domain. The same run also checks that the read-confirm bit arrives alongside read-data-valid.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int MAX_REGS = 64;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 6;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             hit;
    logic [IDX_W-1:0] idx;
  } rfCmd_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                busClk,
  input  logic                busRst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  output rfCmd_t              cmd,
  output logic                readValid,
  output logic [NUM_REGS-1:0] rdStrobe
);
  localparam int WIDE_W = ADDR_W + IDX_W;
  localparam logic [WIDE_W-1:0] NUM_L = WIDE_W'(NUM_REGS);

  logic [WIDE_W-1:0] wordIdx;

  always_comb begin
    wordIdx = {{IDX_W{1'b0}}, busAddr} >> 2;
    cmd.hit = wordIdx < NUM_L;
    cmd.idx = wordIdx[IDX_W-1:0];
    cmd.wr  = busWrite && cmd.hit;
    cmd.rd  = busRead;
  end

  always_ff @(posedge busClk or posedge busRst) begin
    if (busRst) begin
      readValid <= 1'b0;
      rdStrobe  <= '0;
    end else begin
      readValid <= busRead;
      for (int i = 0; i < NUM_REGS; i++)
        rdStrobe[i] <= busRead && cmd.hit && (cmd.idx == IDX_W'(i));
    end
  end

  AST_RDVALID_FOLLOWS: assert property (@(posedge busClk) disable iff (busRst)
    busRead |=> readValid); // R4
  AST_RDVALID_IDLE: assert property (@(posedge busClk) disable iff (busRst)
    !busRead |=> !readValid); // R4
  AST_RDSTROBE_ONEHOT: assert property (@(posedge busClk) disable iff (busRst)
    $onehot0(rdStrobe)); // R8
  AST_RDSTROBE_WITH_VALID: assert property (@(posedge busClk) disable iff (busRst)
    (|rdStrobe) |-> readValid); // R8
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import regfile_pkg::*;
#(
  parameter int                       NUM_REGS   = 8,
  parameter logic [NUM_REGS*32-1:0]   RESET_VALS = '0,
  parameter logic [NUM_REGS*4-1:0]    MODES      = '1
) (
  input  logic                     busClk,
  input  logic                     busRst,
  input  rfCmd_t                   cmd,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [NUM_REGS*32-1:0]   extIn,
  output logic [WORD_W-1:0]        readData,
  output logic [NUM_REGS*32-1:0]   regFlat,
  output logic [NUM_REGS-1:0]      wrPulse
);
  logic [WORD_W-1:0] regs [NUM_REGS];
  logic [WORD_W-1:0] readMux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic RW = MODES[i*4];
    assign regFlat[i*32 +: 32] = regs[i];

    if (RW) begin : g_rw
      always_ff @(posedge busClk or posedge busRst) begin
        if (busRst) begin
          regs[i]    <= RESET_VALS[i*32 +: 32];
          wrPulse[i] <= 1'b0;
        end else begin
          wrPulse[i] <= cmd.wr && (cmd.idx == IDX_W'(i));
          if (cmd.wr && (cmd.idx == IDX_W'(i)))
            regs[i] <= wrData;
        end
      end
    end else begin : g_ro
      always_ff @(posedge busClk or posedge busRst) begin
        if (busRst) regs[i] <= RESET_VALS[i*32 +: 32];
        else        regs[i] <= regs[i];
      end
      assign wrPulse[i] = 1'b0;

      AST_RO_HOLD: assert property (@(posedge busClk) disable iff (busRst)
        $stable(regs[i])); // R5
    end
  end

  always_comb begin
    readMux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (cmd.hit && cmd.idx == IDX_W'(i))
        readMux = MODES[i*4] ? regs[i] : extIn[i*32 +: 32];
  end

  always_ff @(posedge busClk or posedge busRst) begin
    if (busRst)      readData <= '0;
    else if (cmd.rd) readData <= readMux;
  end

  AST_OOR_READ_ZERO: assert property (@(posedge busClk) disable iff (busRst)
    (cmd.rd && !cmd.hit) |=> (readData == '0)); // R6
  AST_OOR_NO_WRITE: assert property (@(posedge busClk) disable iff (busRst)
    !cmd.hit |=> (wrPulse == '0)); // R6
endmodule

// File: rtl/rf_alt_cross.sv
module rf_alt_cross
  import regfile_pkg::*;
#(
  parameter int                     NUM_REGS    = 8,
  parameter bit                     USE_ALT_CLK = 1'b1,
  parameter logic [NUM_REGS*32-1:0] RESET_VALS  = '0
) (
  input  logic                   busClk,
  input  logic                   busRst,
  input  logic                   altClk,
  input  logic                   altRst,
  input  logic [NUM_REGS*32-1:0] regFlat,
  input  logic [NUM_REGS-1:0]    wrPulse,
  output logic [NUM_REGS*32-1:0] regOut,
  output logic [NUM_REGS-1:0]    wrStrobe
);
  if (USE_ALT_CLK) begin : g_alt
    logic [NUM_REGS-1:0] togQ, sync1, sync2, sync3, strobeQ;
    logic [NUM_REGS*32-1:0] outQ;
    logic [NUM_REGS-1:0] edgeSeen;

    always_ff @(posedge busClk or posedge busRst) begin
      if (busRst) togQ <= '0;
      else        togQ <= togQ ^ wrPulse;
    end

    assign edgeSeen = sync2 ^ sync3;

    always_ff @(posedge altClk or posedge altRst) begin
      if (altRst) begin
        sync1   <= '0;
        sync2   <= '0;
        sync3   <= '0;
        strobeQ <= '0;
        outQ    <= RESET_VALS;
      end else begin
        sync1   <= togQ;
        sync2   <= sync1;
        sync3   <= sync2;
        strobeQ <= edgeSeen;
        for (int i = 0; i < NUM_REGS; i++)
          if (edgeSeen[i]) outQ[i*32 +: 32] <= regFlat[i*32 +: 32];
      end
    end

    assign regOut   = outQ;
    assign wrStrobe = strobeQ;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
      AST_OUT_WITH_STROBE: assert property (@(posedge altClk) disable iff (altRst)
        !strobeQ[i] |-> $stable(outQ[i*32 +: 32])); // R9
    end
  end else begin : g_same
    assign regOut   = regFlat;
    assign wrStrobe = wrPulse;
  end
endmodule

// File: rtl/word_regfile_slave.sv
module word_regfile_slave
  import regfile_pkg::*;
#(
  parameter int                     NUM_REGS    = 8,
  parameter int                     ADDR_W      = 8,
  parameter bit                     USE_ALT_CLK = 1'b1,
  parameter logic [NUM_REGS*32-1:0] RESET_VALS  = '0,
  parameter logic [NUM_REGS*4-1:0]  MODES       = '1
) (
  input  logic                   busClk,
  input  logic                   busRst,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrite,
  input  logic [31:0]            busWriteData,
  input  logic                   busRead,
  output logic                   busReadValid,
  output logic [31:0]            busReadData,
  output logic                   busWaitReq,
  input  logic                   altClk,
  input  logic                   altRst,
  input  logic [NUM_REGS*32-1:0] extIn,
  output logic [NUM_REGS*32-1:0] regOut,
  output logic [NUM_REGS-1:0]    wrStrobe,
  output logic [NUM_REGS-1:0]    rdStrobe
);
  initial begin
    if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) $error("NUM_REGS must be 1..64");
    if (ADDR_W < 3) $error("ADDR_W must be at least 3");
  end

  rfCmd_t                 cmd;
  logic [NUM_REGS*32-1:0] regFlat;
  logic [NUM_REGS-1:0]    wrPulse;

  assign busWaitReq = 1'b0;

  rf_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_ctrl (
    .busClk(busClk), .busRst(busRst), .busAddr(busAddr),
    .busWrite(busWrite), .busRead(busRead), .cmd(cmd),
    .readValid(busReadValid), .rdStrobe(rdStrobe)
  );

  rf_datapath #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS), .MODES(MODES)) u_dp (
    .busClk(busClk), .busRst(busRst), .cmd(cmd), .wrData(busWriteData),
    .extIn(extIn), .readData(busReadData), .regFlat(regFlat), .wrPulse(wrPulse)
  );

  rf_alt_cross #(.NUM_REGS(NUM_REGS), .USE_ALT_CLK(USE_ALT_CLK),
                 .RESET_VALS(RESET_VALS)) u_cross (
    .busClk(busClk), .busRst(busRst), .altClk(altClk), .altRst(altRst),
    .regFlat(regFlat), .wrPulse(wrPulse), .regOut(regOut), .wrStrobe(wrStrobe)
  );
endmodule

// File: tb/tb_word_regfile_slave.sv
`timescale 1ns/1ps
module tb_word_regfile_slave;
  localparam int N = 8;

  function automatic logic [N*32-1:0] mkRv();
    logic [N*32-1:0] v;
    for (int i = 0; i < N; i++) v[i*32 +: 32] = 32'hC0DE_0000 + 32'(i) * 32'h0101;
    return v;
  endfunction
  localparam logic [N*32-1:0] RV = mkRv();
  localparam logic [N*4-1:0]  MD = 32'h3003_3333; // regs 5,6 read-only

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h00, 32'h0,         32'hC0DE_0000}, // R3 reset read-back
    '{1'b1, 8'h00, 32'h1111_1111, 32'h0},
    '{1'b0, 8'h00, 32'h0,         32'h1111_1111}, // R4
    '{1'b1, 8'h0B, 32'h2222_2222, 32'h0},         // R2 low bits ignored
    '{1'b0, 8'h08, 32'h0,         32'h2222_2222}, // R2
    '{1'b1, 8'h14, 32'hDEAD_BEEF, 32'h0},         // R5 write to RO
    '{1'b0, 8'h14, 32'h0,         32'hE000_0005}, // R5 returns ext word
    '{1'b1, 8'h40, 32'h1234_5678, 32'h0},         // R6 out of range
    '{1'b0, 8'h40, 32'h0,         32'h0},         // R6
    '{1'b0, 8'h1F, 32'h0,         32'hC0DE_0707}, // R2/R3
    '{1'b1, 8'h1C, 32'h0000_7777, 32'h0},
    '{1'b0, 8'h1D, 32'h0,         32'h0000_7777}  // R4
  };

  logic busClk = 0, altClk = 0, rst = 1;
  logic [7:0] busAddr = '0;
  logic busWrite = 0, busRead = 0;
  logic [31:0] busWriteData = '0;
  logic busReadValid, busWaitReq;
  logic [31:0] busReadData;
  logic [N*32-1:0] extIn, regOut;
  logic [N-1:0] wrStrobe, rdStrobe;

  int checks = 0, fails = 0;
  int wrCount [N];
  logic [31:0] seen3 = '0;
  bit done = 0;

  always #5 busClk = ~busClk;
  always #6.5 altClk = ~altClk;

  initial for (int i = 0; i < N; i++) wrCount[i] = 0;
  always @(posedge altClk)
    if (!rst) for (int i = 0; i < N; i++) if (wrStrobe[i]) wrCount[i]++;
  always @(negedge altClk)
    if (!rst && wrStrobe[3]) seen3 = regOut[3*32 +: 32];

  always_comb for (int i = 0; i < N; i++) extIn[i*32 +: 32] = 32'hE000_0000 + 32'(i);

  word_regfile_slave #(.NUM_REGS(N), .ADDR_W(8), .USE_ALT_CLK(1'b1),
                       .RESET_VALS(RV), .MODES(MD)) dut (
    .busClk(busClk), .busRst(rst), .busAddr(busAddr), .busWrite(busWrite),
    .busWriteData(busWriteData), .busRead(busRead), .busReadValid(busReadValid),
    .busReadData(busReadData), .busWaitReq(busWaitReq), .altClk(altClk),
    .altRst(rst), .extIn(extIn), .regOut(regOut), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge busClk);
    busAddr = a; busWriteData = d; busWrite = 1;
    @(negedge busClk);
    busWrite = 0;
    repeat (8) @(negedge busClk);
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] exp);
    logic [N-1:0] expStb;
    int idx;
    idx = int'(a >> 2);
    expStb = (idx < N) ? N'(1) << idx : '0;
    @(negedge busClk);
    busAddr = a; busRead = 1;
    @(negedge busClk);
    busRead = 0;
    check(busReadValid === 1'b1, "R4 valid", 64'(busReadValid), 64'd1);
    check(busReadData === exp, "R4/R5/R6 data", 64'(busReadData), 64'(exp));
    check(rdStrobe === expStb, "R8 rdStrobe", 64'(rdStrobe), 64'(expStb));
    @(negedge busClk);
    check(busReadValid === 1'b0, "R4 valid idle", 64'(busReadValid), 64'd0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge busClk);
    rst = 0;
    @(negedge busClk);
    // R3 reset state
    check(regOut === RV, "R3 regOut", regOut[63:0], RV[63:0]);
    check(busReadValid === 1'b0, "R3 valid", 64'(busReadValid), 64'd0);
    check(wrStrobe === '0 && rdStrobe === '0, "R3 strobes",
          64'({wrStrobe, rdStrobe}), 64'd0);

    for (int k = 0; k < 12; k++) begin
      if (VEC[k].wr) doWrite(VEC[k].addr, VEC[k].data);
      else           doRead(VEC[k].addr, VEC[k].exp);
    end

    // R7 same-value writes still pulse
    doWrite(8'h00, 32'h1111_1111);
    doWrite(8'h00, 32'h1111_1111);

    // R9 strobe coincides with new output value
    doWrite(8'h0C, 32'h3333_3333);
    check(seen3 === 32'h3333_3333, "R9 out at strobe", 64'(seen3), 64'h3333_3333);

    // R10 write and read of reg 1 in the same cycle; R1 during transfer
    @(negedge busClk);
    busAddr = 8'h04; busWriteData = 32'h0000_0099; busWrite = 1; busRead = 1;
    check(busWaitReq === 1'b0, "R1 waitreq", 64'(busWaitReq), 64'd0);
    @(negedge busClk);
    busWrite = 0; busRead = 0;
    check(busReadData === 32'hC0DE_0101, "R10 old value", 64'(busReadData), 64'hC0DE_0101);
    check(rdStrobe === 8'h02 && busReadValid, "R10/R8 confirm", 64'(rdStrobe), 64'h02);
    repeat (8) @(negedge busClk);
    doRead(8'h04, 32'h0000_0099); // R10 new value stored
    check(busWaitReq === 1'b0, "R1 waitreq idle", 64'(busWaitReq), 64'd0);

    repeat (10) @(negedge busClk);
    // R7/R5/R6 strobe counts
    begin
      int expCnt [N] = '{3, 1, 1, 1, 0, 0, 0, 1};
      for (int i = 0; i < N; i++)
        check(wrCount[i] == expCnt[i], $sformatf("R7 count reg%0d", i),
              64'(wrCount[i]), 64'(expCnt[i]));
    end
    // R9/R5 final output words
    begin
      logic [31:0] expOut [N] = '{32'h1111_1111, 32'h99, 32'h2222_2222, 32'h3333_3333,
                                  32'hC0DE_0404, 32'hC0DE_0505, 32'hC0DE_0606, 32'h7777};
      for (int i = 0; i < N; i++)
        check(regOut[i*32 +: 32] === expOut[i], $sformatf("R9/R5 regOut%0d", i),
              64'(regOut[i*32 +: 32]), 64'(expOut[i]));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule